// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive path of a 10/100 Ethernet MAC and decides, once per frame, whether the frame is kept or discarded. It watches the first six bytes of each incoming frame, which form the destination address. It compares them against the programmed station address and tests for broadcast. For group (multicast) addresses it applies a pass-all rule or a 64-bin hash table, as configured. A promiscuous setting overrides all of these checks. In half duplex, a drop-own setting rejects frames that overlap the local transmitter.

Bytes arrive on a valid/ready stream, and a start-of-frame flag marks the first destination byte. The filter never applies back-pressure: `in_ready` is held high outside reset, so a byte transfers on every clock edge where `in_valid` is high. Bytes that follow the sixth address byte, and bytes that arrive before any start-of-frame, pass through without effect. The hash bin is the top six bits of a CRC-32 register that is updated one byte per clock while the address streams in. The decision therefore costs one extra cycle and no per-frame buffer.

Top module: `rx_addr_filter`

## Requirements
- R1: `in_ready` is 1 whenever reset is released. A byte is taken only on an edge where `in_valid` is 1, so idle cycles between address bytes do not disturb the result. Bytes taken before any start-of-frame, or after the sixth address byte, change neither `dec_valid` nor `accept`.
- R2: A byte taken with `in_sof` = 1 becomes address byte 0, even when an earlier address was incomplete. On the edge that takes it, `dec_valid` and `accept` go to 0.
- R3: `dec_valid` rises on the clock edge after the edge that takes address byte 5. It stays low until that edge, and it holds with `accept` unchanged until the next start-of-frame byte.
- R4: Address byte k (k = 0..3) is compared with `sta_lo[8k+7:8k]`, byte 4 with `sta_hi[7:0]` and byte 5 with `sta_hi[15:8]`. The frame is accepted when all six bytes are equal and rejected when any byte differs and no other rule applies.
- R5: An address of six 0xFF bytes is always accepted, whatever the station address and the multicast settings.
- R6: A frame is a group frame when bit 0 of address byte 0 is 1. With `cfg_all_multi` = 1, every group frame is accepted without reference to the hash table.
- R7: The hash bin is bits 31:26 of a CRC register. The register starts at all ones and is shifted LSB first through the six address bytes with the reflected polynomial 0xEDB88320, with no final inversion. Bins 0..31 are `hash_lo[bin]` and bins 32..63 are `hash_hi[bin-32]`. With `cfg_hash_en` = 1, a group frame is accepted exactly when its bin bit is 1.
- R8: A non-broadcast group frame is rejected when both `cfg_all_multi` and `cfg_hash_en` are 0.
- R9: With `cfg_promisc` = 1, every frame is accepted, including frames covered by R10.
- R10: With `cfg_drop_own` = 1 and `cfg_promisc` = 0, a frame is rejected if `tx_active` was 1 on any edge that took one of its address bytes. With `cfg_drop_own` = 0, `tx_active` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Receive byte valid |
| in_ready | output | 1 | Always 1 after reset; the filter never stalls |
| in_sof | input | 1 | Marks the first destination byte |
| in_data | input | 8 | Receive byte |
| sta_hi | input | 16 | Station address bytes 5 (15:8) and 4 (7:0) |
| sta_lo | input | 32 | Station address bytes 3..0, byte 0 in 7:0 |
| hash_hi | input | 32 | Hash bins 63..32 |
| hash_lo | input | 32 | Hash bins 31..0 |
| cfg_promisc | input | 1 | Accept every frame |
| cfg_all_multi | input | 1 | Accept every group frame |
| cfg_hash_en | input | 1 | Filter group frames through the hash table |
| cfg_drop_own | input | 1 | Reject frames overlapping local transmission |
| tx_active | input | 1 | Local transmitter busy |
| dec_valid | output | 1 | Decision available for the current frame |
| accept | output | 1 | 1 = keep frame, 0 = discard |

## Verification
Three kinds of internal fault show up at the ports. A wrong byte count or a missed restart moves the rising edge of `dec_valid` away from the single cycle after byte 5, which is visible on the very next frame. A CRC or bin-select error flips `accept` only for group addresses whose bin is at the boundary being tested. The bench therefore searches for addresses landing in both hash halves and arms exactly one bin, then every bin but that one. A stale own-transmit flag shows as a rejection in a following frame sent with `tx_active` low.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned ADDR_BYTES = 6;
  localparam int unsigned ADDR_W     = BYTE_W * ADDR_BYTES;
  localparam int unsigned CRC_W      = 32;
  localparam int unsigned BIN_W      = 6;
  localparam int unsigned CNT_W      = $clog2(ADDR_BYTES + 1);
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_SEED = '1;

  typedef logic [ADDR_W-1:0] mac_addr_t;

  typedef struct packed {
    logic promisc;
    logic all_multi;
    logic hash_en;
    logic drop_own;
  } filt_cfg_t;
endpackage

// File: rtl/rxf_crc_step.sv
module rxf_crc_step
  import rxf_pkg::*;
(
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [BYTE_W-1:0] data,
  output logic [CRC_W-1:0]  crc_out
);
  logic [CRC_W-1:0] stage [BYTE_W+1];

  assign stage[0] = crc_in;

  for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
    logic fb;
    assign fb = stage[b][0] ^ data[b];
    assign stage[b+1] = (stage[b] >> 1) ^ (fb ? CRC_POLY : '0);
  end

  assign crc_out = stage[BYTE_W];
endmodule

// File: rtl/rxf_capture.sv
module rxf_capture
  import rxf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              tx_active,
  output mac_addr_t         addr_q,
  output logic [CRC_W-1:0]  crc_q,
  output logic              own_q,
  output logic              full_q
);
  localparam logic [CNT_W-1:0] DONE = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] idx;
  logic             take;
  logic [CRC_W-1:0] crc_base;
  logic [CRC_W-1:0] crc_next;

  assign take     = in_valid && (in_sof || (cnt_q != DONE));
  assign idx      = in_sof ? '0 : cnt_q;
  assign crc_base = in_sof ? CRC_SEED : crc_q;

  rxf_crc_step u_step (
    .crc_in  (crc_base),
    .data    (in_data),
    .crc_out (crc_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= DONE;
      addr_q <= '0;
      crc_q  <= CRC_SEED;
      own_q  <= 1'b0;
      full_q <= 1'b0;
    end else begin
      full_q <= take && (idx == LAST);
      if (take) begin
        cnt_q  <= idx + 1'b1;
        addr_q <= {in_data, addr_q[ADDR_W-1:BYTE_W]};
        crc_q  <= crc_next;
        own_q  <= in_sof ? tx_active : (own_q | tx_active);
      end
    end
  end
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             full_q,
  input  mac_addr_t        addr_q,
  input  logic [CRC_W-1:0] crc_q,
  input  logic             own_q,
  input  mac_addr_t        station,
  input  logic [63:0]      hash_tbl,
  input  filt_cfg_t        cfg,
  output logic             dec_valid,
  output logic             accept
);
  logic [BIN_W-1:0] bin;
  logic is_bcast, is_group, is_mine, hash_hit, own_drop, verdict;

  assign bin      = crc_q[CRC_W-1 -: BIN_W];
  assign is_bcast = &addr_q;
  assign is_group = addr_q[0];
  assign is_mine  = (addr_q == station);
  assign hash_hit = hash_tbl[bin];
  assign own_drop = cfg.drop_own && own_q;

  always_comb begin
    verdict = is_mine || is_bcast ||
              (is_group && (cfg.all_multi || (cfg.hash_en && hash_hit)));
    verdict = cfg.promisc || (verdict && !own_drop);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      accept    <= 1'b0;
    end else if (restart) begin
      dec_valid <= 1'b0;
      accept    <= 1'b0;
    end else if (full_q) begin
      dec_valid <= 1'b1;
      accept    <= verdict;
    end
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        in_sof,
  input  logic [7:0]  in_data,
  input  logic [15:0] sta_hi,
  input  logic [31:0] sta_lo,
  input  logic [31:0] hash_hi,
  input  logic [31:0] hash_lo,
  input  logic        cfg_promisc,
  input  logic        cfg_all_multi,
  input  logic        cfg_hash_en,
  input  logic        cfg_drop_own,
  input  logic        tx_active,
  output logic        dec_valid,
  output logic        accept
);
  mac_addr_t        addr_q;
  logic [CRC_W-1:0] crc_q;
  logic             own_q;
  logic             full_q;
  filt_cfg_t        cfg;
  logic             ready_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign in_ready = ready_q;

  assign cfg = '{promisc: cfg_promisc, all_multi: cfg_all_multi,
                 hash_en: cfg_hash_en, drop_own: cfg_drop_own};

  rxf_capture u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid && ready_q),
    .in_sof    (in_sof),
    .in_data   (in_data),
    .tx_active (tx_active),
    .addr_q    (addr_q),
    .crc_q     (crc_q),
    .own_q     (own_q),
    .full_q    (full_q)
  );

  rxf_decide u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (in_valid && ready_q && in_sof),
    .full_q    (full_q),
    .addr_q    (addr_q),
    .crc_q     (crc_q),
    .own_q     (own_q),
    .station   ({sta_hi, sta_lo}),
    .hash_tbl  ({hash_hi, hash_lo}),
    .cfg       (cfg),
    .dec_valid (dec_valid),
    .accept    (accept)
  );
endmodule

// File: rtl/rx_addr_filter_checker.sv
module rx_addr_filter_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        in_sof,
  input logic [15:0] sta_hi,
  input logic [31:0] sta_lo,
  input logic        cfg_promisc,
  input logic        cfg_drop_own,
  input logic [47:0] addr_q,
  input logic        own_q,
  input logic        dec_valid,
  input logic        accept
);
  logic [2:0] seen_q;
  logic       take;

  assign take = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)                     seen_q <= 3'd6;
    else if (take && in_sof)        seen_q <= 3'd1;
    else if (take && seen_q != 3'd6) seen_q <= seen_q + 3'd1;
  end

  a_r2_sof_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_sof) |=> !dec_valid);

  a_r3_after_six: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_valid) |-> (seen_q == 3'd6));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !(take && in_sof)) |=> (dec_valid && $stable(accept)));

  a_r5_bcast: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dec_valid) && $past(&addr_q && !(cfg_drop_own && own_q))) |-> accept);

  a_r4_station: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dec_valid) && $past(addr_q == {sta_hi, sta_lo} && !own_q)) |-> accept);

  a_r9_promisc: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dec_valid) && $past(cfg_promisc)) |-> accept);

  a_r10_own_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dec_valid) && $past(cfg_drop_own && own_q && !cfg_promisc)) |-> !accept);
endmodule

bind rx_addr_filter rx_addr_filter_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_sof       (in_sof),
  .sta_hi       (sta_hi),
  .sta_lo       (sta_lo),
  .cfg_promisc  (cfg_promisc),
  .cfg_drop_own (cfg_drop_own),
  .addr_q       (addr_q),
  .own_q        (own_q),
  .dec_valid    (dec_valid),
  .accept       (accept)
);

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, tx_active = 1'b0;
  logic [7:0] in_data = '0;
  logic [15:0] sta_hi = 16'h5544;
  logic [31:0] sta_lo = 32'h33221100;
  logic [31:0] hash_hi = '0, hash_lo = '0;
  logic cfg_promisc = 0, cfg_all_multi = 0, cfg_hash_en = 0, cfg_drop_own = 0;
  logic in_ready, dec_valid, accept;

  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rx_addr_filter u_rx_addr_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_data(in_data), .sta_hi(sta_hi), .sta_lo(sta_lo),
    .hash_hi(hash_hi), .hash_lo(hash_lo), .cfg_promisc(cfg_promisc),
    .cfg_all_multi(cfg_all_multi), .cfg_hash_en(cfg_hash_en),
    .cfg_drop_own(cfg_drop_own), .tx_active(tx_active),
    .dec_valid(dec_valid), .accept(accept)
  );

  localparam logic [47:0] STA   = 48'h5544_3322_1100;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

  task automatic check(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  function automatic logic [5:0] bin_of(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < 48; i++) begin
      logic f = c[0] ^ a[i];
      c = c >> 1;
      if (f) c = c ^ 32'hEDB88320;
    end
    return c[31:26];
  endfunction

  task automatic put_byte(input logic [7:0] d, input logic sof, input logic tx);
    @(negedge clk);
    in_valid = 1; in_sof = sof; in_data = d; tx_active = tx;
  endtask

  // sends 6 address bytes (byte 0 = a[7:0]); checks R3 timing, returns accept
  task automatic send_addr(input logic [47:0] a, input logic [5:0] txm,
                           input bit gap, output logic acc);
    for (int i = 0; i < 6; i++) begin
      put_byte(a[8*i +: 8], i == 0, txm[i]);
      if (gap && i == 2) begin
        @(negedge clk); in_valid = 0; in_sof = 0; tx_active = 0;
        in_data = 8'hA5;
      end
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; tx_active = 0;
    check("R3 not early", dec_valid, 1'b0);
    @(negedge clk);
    check("R3 valid one cycle later", dec_valid, 1'b1);
    acc = accept;
  endtask

  task automatic frame(input string req, input logic [47:0] a,
                       input logic [5:0] txm, input logic exp);
    logic acc;
    send_addr(a, txm, 1'b0, acc);
    check(req, acc, exp);
  endtask

  task automatic t_reset;
    check("R1 ready after reset", in_ready, 1'b1);
    check("R3 no decision at reset", dec_valid, 1'b0);
    check("R2 accept low at reset", accept, 1'b0);
    // R1 bytes without any start-of-frame are ignored
    for (int i = 0; i < 8; i++) put_byte(8'hFF, 1'b0, 1'b0);
    @(negedge clk); in_valid = 0;
    @(negedge clk);
    check("R1 bytes before sof ignored", dec_valid, 1'b0);
  endtask

  task automatic t_unicast;
    logic acc;
    frame("R4 station match", STA, 6'h00, 1'b1);
    frame("R4 byte5 differs", STA ^ 48'h0100_0000_0000, 6'h00, 1'b0);
    frame("R4 byte0 differs", STA ^ 48'h0000_0000_0002, 6'h00, 1'b0);
    send_addr(STA, 6'h00, 1'b1, acc);
    check("R1 idle gap tolerated", acc, 1'b1);
  endtask

  task automatic t_hold_restart;
    logic acc;
    send_addr(STA, 6'h00, 1'b0, acc);
    for (int i = 0; i < 5; i++) put_byte(8'h00, 1'b0, 1'b0);
    @(negedge clk); in_valid = 0;
    check("R3 held over payload", dec_valid, 1'b1);
    check("R1 payload ignored", accept, 1'b1);
    put_byte(8'h00, 1'b1, 1'b0);
    @(negedge clk); in_valid = 0; in_sof = 0;
    check("R2 sof clears valid", dec_valid, 1'b0);
    // restart mid-address: three junk bytes, then a full station address
    put_byte(8'h77, 1'b0, 1'b0);
    put_byte(8'h77, 1'b0, 1'b0);
    send_addr(STA, 6'h00, 1'b0, acc);
    check("R2 restart on sof", acc, 1'b1);
  endtask

  task automatic t_bcast_multi;
    frame("R5 broadcast, no modes", BCAST, 6'h00, 1'b1);
    frame("R8 group without modes", 48'h0100_005E_0001, 6'h00, 1'b0);
    cfg_all_multi = 1;
    frame("R6 pass all multicast", 48'h0100_005E_0001, 6'h00, 1'b1);
    frame("R6 unicast still filtered", 48'h0100_005E_0000, 6'h00, 1'b0);
    cfg_all_multi = 0;
  endtask

  task automatic t_hash;
    logic [47:0] a_lo = '0, a_hi = '0;
    bit got_lo = 0, got_hi = 0;
    for (int k = 0; k < 256; k++) begin
      logic [47:0] a = {8'(k), 40'h00_5E_00_00_01};
      logic [5:0] b = bin_of(a);
      if (!b[5] && !got_lo) begin a_lo = a; got_lo = 1; end
      if (b[5] && !got_hi) begin a_hi = a; got_hi = 1; end
    end
    cfg_hash_en = 1;
    begin
      logic [63:0] t = 64'd1 << bin_of(a_lo);
      hash_hi = t[63:32]; hash_lo = t[31:0];
      frame("R7 low-half bin hit", a_lo, 6'h00, 1'b1);
      hash_hi = ~t[63:32]; hash_lo = ~t[31:0];
      frame("R7 low-half bin miss", a_lo, 6'h00, 1'b0);
      t = 64'd1 << bin_of(a_hi);
      hash_hi = t[63:32]; hash_lo = t[31:0];
      frame("R7 high-half bin hit", a_hi, 6'h00, 1'b1);
      hash_hi = ~t[63:32]; hash_lo = ~t[31:0];
      frame("R7 high-half bin miss", a_hi, 6'h00, 1'b0);
    end
    hash_hi = '1; hash_lo = '1;
    frame("R7 hash ignores unicast", 48'h0000_0000_0002, 6'h00, 1'b0);
    cfg_hash_en = 0;
    frame("R8 hash disabled", a_lo, 6'h00, 1'b0);
    hash_hi = '0; hash_lo = '0;
  endtask

  task automatic t_own_promisc;
    frame("R10 tx ignored when drop off", STA, 6'h3F, 1'b1);
    cfg_drop_own = 1;
    frame("R10 own frame dropped", STA, 6'h08, 1'b0);
    frame("R10 broadcast own dropped", BCAST, 6'h01, 1'b0);
    frame("R10 next frame clean", STA, 6'h00, 1'b1);
    cfg_promisc = 1;
    frame("R9 promisc beats own drop", STA, 6'h20, 1'b1);
    frame("R9 promisc any address", 48'h0102_0304_0506, 6'h00, 1'b1);
    cfg_promisc = 0; cfg_drop_own = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_unicast;
    t_hold_restart;
    t_bcast_multi;
    t_hash;
    t_own_promisc;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule